// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block is the timing and state controller of a DMA engine that serves one channel at a time. While idle it looks at the request input on every clock. When a request is present it raises a bus hold request and waits for the processor to grant the bus. It then walks through four working states, one clock each, and drives the memory and I/O read and write strobes. The memory and I/O strobes are paired so that data moves straight between the two sides and never passes through the block.

Three transfer kinds are supported. In I/O-to-memory, the I/O read and the memory write are driven together. In memory-to-I/O, the memory read and the I/O write are driven together. In memory-to-memory, an eight-state move runs: a four-state read half followed by a four-state write half. A ready input stretches a transfer with wait states. A build parameter places those wait states after the second or the third working state. Another parameter sets how many synchronizing flops the ready input passes through.

Address generation, count handling and channel priority belong to neighbouring blocks. This block tells them about each finished transfer with a one-cycle done pulse. A permission output tells the register file when the processor may still program the engine.

Top module: `dma_cycle_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the block in the idle state. In that state `hold_req_o`, all four strobes and `xfer_done_o` are low, and `prog_ok_o` is high.
- R2: While idle, the block stays idle as long as `req_i` is low. `req_i` is sampled at every rising edge. The cycle after an edge that sees it high, `hold_req_o` is high.
- R3: In the hold-wait state, `hold_req_o` stays high and the block remains there for as long as `hold_ack_i` is low, even if `req_i` drops. The edge that sees `hold_ack_i` high moves the block to the first working state.
- R4: Each working state lasts one clock. Take an edge that starts a transfer. The cycle after it (first working state) has no strobe. The next two cycles (second and third states) carry the read strobe, and the third of these cycles also carries the write strobe. The fourth working state follows with no strobe. With ready high, no wait state occurs.
- R5: Mode `xfer_mode_i = 2'b00` (I/O-to-memory) drives `io_rd_o` as the read strobe and `mem_wr_o` as the write strobe. `mem_rd_o` and `io_wr_o` stay low.
- R6: Mode `2'b01` (memory-to-I/O) drives `mem_rd_o` as the read strobe and `io_wr_o` as the write strobe. `io_rd_o` and `mem_wr_o` stay low.
- R7: A mode with bit 1 set (`2'b10` or `2'b11`, memory-to-memory) runs eight working states. The first four drive only `mem_rd_o`, in their second and third states. The last four drive only `mem_wr_o`, in their third state. `xfer_done_o` fires only at the end of the write half, and the I/O strobes stay low.
- R8: `WAIT_POINT` (2 or 3) selects the working state in which ready is checked. If the check sees ready low, wait states follow in place of the rest of the second-to-fourth path. A wait state drives the strobes of the third state and repeats until ready is seen high; the fourth state then follows. In memory-to-memory, each half applies the same rule.
- R9: With `READY_SYNC_STAGES = N`, the ready value used in a cycle is `ready_i` as it was N rising edges earlier. After reset this delayed value reads as high.
- R10: `xfer_done_o` is high for exactly the one cycle of the final fourth state. At the next edge, `req_i` and `hold_ack_i` both high start a new transfer directly; `req_i` high alone returns the block to hold-wait; `req_i` low returns it to idle.
- R11: The mode is captured at the edge that starts a transfer. Changes to `xfer_mode_i` during the transfer do not alter its strobes.
- R12: `prog_ok_o` is high exactly in the idle and hold-wait states and low throughout every working and wait state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | DMA request from the selected channel |
| hold_ack_i | input | 1 | Bus grant from the processor |
| ready_i | input | 1 | Slave ready; low requests wait states |
| xfer_mode_i | input | 2 | 00 I/O-to-memory, 01 memory-to-I/O, 1x memory-to-memory |
| hold_req_o | output | 1 | Bus hold request |
| prog_ok_o | output | 1 | Register programming permitted |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| xfer_done_o | output | 1 | One-cycle pulse per finished transfer |

## Verification
The bench builds two copies side by side on the same stimulus. The first uses the defaults: wait states after the third state and ready used directly. The second uses wait states after the second state and one synchronizing flop on ready. Between them, both wait placements are exercised, including the case where the wait replaces the third state. The ready latency that the synchronizer adds is also exercised. Directed runs and a long random run then cover back-to-back transfers, mode changes in mid-transfer and the loss of the bus grant against both copies.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   localparam int MODE_W = 2;

   // sequencer states, one clock each
   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_HOLD = 3'd1,
      SQ_T1   = 3'd2,
      SQ_T2   = 3'd3,
      SQ_T3   = 3'd4,
      SQ_TW   = 3'd5,
      SQ_T4   = 3'd6
   } seq_state_e;

   typedef struct packed {
      logic mem_rd;
      logic mem_wr;
      logic io_rd;
      logic io_wr;
   } strobe_t;

   // mode bit 1 selects the two-half memory-to-memory move
   function automatic logic is_m2m(input logic [MODE_W-1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/dma_seq_ready_sync.sv
module dma_seq_ready_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic rdy_i,
   output logic rdy_o
);

   initial begin : prm_chk
      if (STAGES < 0 || STAGES > 4)
         $error("dma_seq_ready_sync: STAGES must lie in 0..4");
   end

   generate
      if (STAGES == 0) begin : g_direct
         assign rdy_o = rdy_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (rst) sh_q[0] <= 1'b1;
            else     sh_q[0] <= rdy_i;
         end
         for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
               if (rst) sh_q[g] <= 1'b1;
               else     sh_q[g] <= sh_q[g-1];
            end
         end
         assign rdy_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
   import dma_seq_pkg::*;
#(
   parameter int WAIT_POINT = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_i,
   input  logic              ack_i,
   input  logic              rdy_i,
   input  logic [MODE_W-1:0] mode_i,
   output seq_state_e        state_o,
   output logic              half_o,
   output logic [MODE_W-1:0] mode_o
);

   initial begin : prm_chk
      if (WAIT_POINT != 2 && WAIT_POINT != 3)
         $error("dma_seq_fsm: WAIT_POINT must be 2 or 3");
   end

   seq_state_e        state_q, state_d;
   logic              half_q, half_d;
   logic [MODE_W-1:0] mode_q, mode_d;
   logic              stall_t2, stall_t3;

   generate
      if (WAIT_POINT == 2) begin : g_wait_t2
         assign stall_t2 = !rdy_i;
         assign stall_t3 = 1'b0;
      end else begin : g_wait_t3
         assign stall_t2 = 1'b0;
         assign stall_t3 = !rdy_i;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      half_d  = half_q;
      mode_d  = mode_q;
      unique case (state_q)
         SQ_IDLE: if (req_i) state_d = SQ_HOLD;
         SQ_HOLD: if (ack_i) begin
            state_d = SQ_T1;
            half_d  = 1'b0;
            mode_d  = mode_i;
         end
         SQ_T1: state_d = SQ_T2;
         SQ_T2: state_d = stall_t2 ? SQ_TW : SQ_T3;
         SQ_T3: state_d = stall_t3 ? SQ_TW : SQ_T4;
         SQ_TW: if (rdy_i) state_d = SQ_T4;
         SQ_T4: begin
            if (is_m2m(mode_q) && !half_q) begin
               state_d = SQ_T1;
               half_d  = 1'b1;
            end else if (req_i && ack_i) begin
               state_d = SQ_T1;
               half_d  = 1'b0;
               mode_d  = mode_i;
            end else if (req_i) begin
               state_d = SQ_HOLD;
            end else begin
               state_d = SQ_IDLE;
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SQ_IDLE;
         half_q  <= 1'b0;
         mode_q  <= '0;
      end else begin
         state_q <= state_d;
         half_q  <= half_d;
         mode_q  <= mode_d;
      end
   end

   assign state_o = state_q;
   assign half_o  = half_q;
   assign mode_o  = mode_q;

   // R8
   wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == SQ_TW && !rdy_i) |=> (state_q == SQ_TW));

   // R3
   hold_stay_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == SQ_HOLD && !ack_i) |=> (state_q == SQ_HOLD));

   // R4
   step_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == SQ_T1) |=> (state_q == SQ_T2));

   // R11
   mode_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q inside {SQ_T1, SQ_T2, SQ_T3, SQ_TW}) |=> $stable(mode_q));

endmodule

// File: rtl/dma_seq_strobe.sv
module dma_seq_strobe
   import dma_seq_pkg::*;
(
   input  seq_state_e        state_i,
   input  logic              half_i,
   input  logic [MODE_W-1:0] mode_i,
   output strobe_t           stb_o,
   output logic              hold_o,
   output logic              prog_o,
   output logic              done_o
);

   logic rd_phase, wr_phase;

   always_comb begin
      rd_phase = (state_i == SQ_T2) || (state_i == SQ_T3) || (state_i == SQ_TW);
      wr_phase = (state_i == SQ_T3) || (state_i == SQ_TW);
      stb_o    = '0;
      if (is_m2m(mode_i)) begin
         if (!half_i) stb_o.mem_rd = rd_phase;
         else         stb_o.mem_wr = wr_phase;
      end else if (mode_i[0]) begin
         stb_o.mem_rd = rd_phase;
         stb_o.io_wr  = wr_phase;
      end else begin
         stb_o.io_rd  = rd_phase;
         stb_o.mem_wr = wr_phase;
      end
      hold_o = (state_i != SQ_IDLE);
      prog_o = (state_i == SQ_IDLE) || (state_i == SQ_HOLD);
      done_o = (state_i == SQ_T4) && !(is_m2m(mode_i) && !half_i);
   end

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
   import dma_seq_pkg::*;
#(
   parameter int WAIT_POINT        = 3,
   parameter int READY_SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       req_i,
   input  logic       hold_ack_i,
   input  logic       ready_i,
   input  logic [1:0] xfer_mode_i,
   output logic       hold_req_o,
   output logic       prog_ok_o,
   output logic       mem_rd_o,
   output logic       mem_wr_o,
   output logic       io_rd_o,
   output logic       io_wr_o,
   output logic       xfer_done_o
);

   logic              rdy_eff;
   seq_state_e        state;
   logic              half;
   logic [MODE_W-1:0] mode_cur;
   strobe_t           stb;
   logic              any_stb;

   dma_seq_ready_sync #(.STAGES(READY_SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .rdy_i (ready_i),
      .rdy_o (rdy_eff)
   );

   dma_seq_fsm #(.WAIT_POINT(WAIT_POINT)) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .req_i   (req_i),
      .ack_i   (hold_ack_i),
      .rdy_i   (rdy_eff),
      .mode_i  (xfer_mode_i),
      .state_o (state),
      .half_o  (half),
      .mode_o  (mode_cur)
   );

   dma_seq_strobe u_stb (
      .state_i (state),
      .half_i  (half),
      .mode_i  (mode_cur),
      .stb_o   (stb),
      .hold_o  (hold_req_o),
      .prog_o  (prog_ok_o),
      .done_o  (xfer_done_o)
   );

   assign mem_rd_o = stb.mem_rd;
   assign mem_wr_o = stb.mem_wr;
   assign io_rd_o  = stb.io_rd;
   assign io_wr_o  = stb.io_wr;
   assign any_stb  = mem_rd_o | mem_wr_o | io_rd_o | io_wr_o;

   // R2
   idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
      (!hold_req_o && !req_i) |=> !hold_req_o);

   // R3
   hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (hold_req_o && prog_ok_o && !hold_ack_i) |=> (hold_req_o && prog_ok_o));

   // R12
   strobe_owner_chk: assert property (@(posedge clk) disable iff (rst)
      any_stb |-> (hold_req_o && !prog_ok_o));

   // R7
   mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd_o && mem_wr_o));

   // R5
   io_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(io_rd_o && io_wr_o));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      xfer_done_o |=> !xfer_done_o);

   // R4
   done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      xfer_done_o |-> !any_stb);

endmodule

// File: tb/dma_cycle_seq_tb_top.sv
module dma_cycle_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req = 1'b0, ack = 1'b0, rdy = 1'b1;
   logic [1:0] mode = 2'b00;

   logic [6:0] out_v [2];
   logic       a_hold, a_prog, a_mrd, a_mwr, a_iord, a_iowr, a_done;
   logic       b_hold, b_prog, b_mrd, b_mwr, b_iord, b_iowr, b_done;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit checking = 1'b0, finished = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   dma_cycle_seq #(.WAIT_POINT(3), .READY_SYNC_STAGES(0)) dut_i (
      .clk(clk), .rst(rst), .req_i(req), .hold_ack_i(ack), .ready_i(rdy),
      .xfer_mode_i(mode), .hold_req_o(a_hold), .prog_ok_o(a_prog),
      .mem_rd_o(a_mrd), .mem_wr_o(a_mwr), .io_rd_o(a_iord), .io_wr_o(a_iowr),
      .xfer_done_o(a_done));

   dma_cycle_seq #(.WAIT_POINT(2), .READY_SYNC_STAGES(1)) dut_b (
      .clk(clk), .rst(rst), .req_i(req), .hold_ack_i(ack), .ready_i(rdy),
      .xfer_mode_i(mode), .hold_req_o(b_hold), .prog_ok_o(b_prog),
      .mem_rd_o(b_mrd), .mem_wr_o(b_mwr), .io_rd_o(b_iord), .io_wr_o(b_iowr),
      .xfer_done_o(b_done));

   assign out_v[0] = {a_hold, a_prog, a_mrd, a_mwr, a_iord, a_iowr, a_done};
   assign out_v[1] = {b_hold, b_prog, b_mrd, b_mwr, b_iord, b_iowr, b_done};

   // reference model: 0 idle, 1 hold-wait, 2..4 first..third, 5 wait, 6 fourth
   int m_st [2], m_half [2], m_md [2], m_rq [2];
   int m_wp [2] = '{3, 2};
   int m_sy [2] = '{0, 1};

   function automatic logic [6:0] model_out(int i);
      bit rdp, wrp, m2m;
      logic [6:0] v;
      rdp = (m_st[i] >= 3 && m_st[i] <= 5);
      wrp = (m_st[i] == 4 || m_st[i] == 5);
      m2m = (m_md[i] >= 2);
      v = '0;
      v[6] = (m_st[i] != 0);
      v[5] = (m_st[i] <= 1);
      if (m2m) begin
         if (m_half[i] == 0) v[4] = rdp; else v[3] = wrp;
      end else if (m_md[i] == 1) begin
         v[4] = rdp; v[0] = 1'b0; v[1] = wrp;
      end else begin
         v[2] = rdp; v[3] = wrp;
      end
      v[0] = (m_st[i] == 6) && !(m2m && m_half[i] == 0);
      return v;
   endfunction

   task automatic model_step(int i);
      int re;
      if (rst) begin
         m_st[i] = 0; m_half[i] = 0; m_md[i] = 0; m_rq[i] = 1;
         return;
      end
      re = (m_sy[i] != 0) ? m_rq[i] : int'(rdy);
      case (m_st[i])
         0: if (req) m_st[i] = 1;
         1: if (ack) begin m_st[i] = 2; m_half[i] = 0; m_md[i] = int'(mode); end
         2: m_st[i] = 3;
         3: m_st[i] = (m_wp[i] == 2 && re == 0) ? 5 : 4;
         4: m_st[i] = (m_wp[i] == 3 && re == 0) ? 5 : 6;
         5: if (re != 0) m_st[i] = 6;
         default: begin
            if (m_md[i] >= 2 && m_half[i] == 0) begin
               m_st[i] = 2; m_half[i] = 1;
            end else if (req && ack) begin
               m_st[i] = 2; m_half[i] = 0; m_md[i] = int'(mode);
            end else if (req) m_st[i] = 1;
            else m_st[i] = 0;
         end
      endcase
      m_rq[i] = int'(rdy);
   endtask

   always @(posedge clk) begin
      model_step(0);
      model_step(1);
   end

   function automatic string pick_tag(int i, logic [6:0] act, logic [6:0] exp);
      if (act[5] != exp[5]) return "R12";
      if (act[6] != exp[6]) return (m_st[i] == 1) ? "R3" : "R2";
      if (act[0] != exp[0]) return "R10";
      if (m_st[i] == 5) return (i == 1) ? "R9" : "R8";
      if (m_md[i] != int'(mode)) return "R11";
      if (m_st[i] == 2 || m_st[i] == 6) return "R4";
      if (m_md[i] >= 2) return "R7";
      if (m_md[i] == 1) return "R6";
      return "R5";
   endfunction

   task automatic check_vec(string tag, int i, logic [6:0] act, logic [6:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s dut%0d cycle %0d actual %b expected %b (hold,prog,mrd,mwr,iord,iowr,done)",
                  tag, i, cyc, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (checking && !finished) begin
         for (int i = 0; i < 2; i++) begin
            logic [6:0] e;
            e = model_out(i);
            check_vec(pick_tag(i, out_v[i], e), i, out_v[i], e);
         end
      end
   end

   task automatic drive(input logic r, input logic a, input logic y, input logic [1:0] m, input int n);
      req = r; ack = a; rdy = y; mode = m;
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // watchdog: an expired run is a failed check
   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000 && !finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired at cycle %0d (actual running, expected finished)", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state, fixed expectation hold=0 prog=1 rest 0
      check_vec("R1", 0, out_v[0], 7'b0100000);
      check_vec("R1", 1, out_v[1], 7'b0100000);
      rst = 1'b0;
      checking = 1'b1;

      // R2: idle while no request
      drive(1'b0, 1'b0, 1'b1, 2'b00, 5);
      // R2 / R3: request, then grant after a delay; request dropped during hold-wait
      drive(1'b1, 1'b0, 1'b1, 2'b00, 2);
      drive(1'b0, 1'b0, 1'b1, 2'b00, 3);
      // R4 / R5: I/O-to-memory transfer, grant arrives
      drive(1'b1, 1'b1, 1'b1, 2'b00, 5);
      // R10: back-to-back, then drop request
      drive(1'b1, 1'b1, 1'b1, 2'b00, 4);
      drive(1'b0, 1'b1, 1'b1, 2'b00, 6);
      // R6 / R8 / R9: memory-to-I/O with ready low for several cycles
      drive(1'b1, 1'b1, 1'b1, 2'b01, 3);
      drive(1'b1, 1'b1, 1'b0, 2'b01, 4);
      drive(1'b0, 1'b1, 1'b1, 2'b01, 8);
      // R7: memory-to-memory with waits in both halves
      drive(1'b1, 1'b1, 1'b1, 2'b10, 2);
      drive(1'b0, 1'b1, 1'b0, 2'b10, 3);
      drive(1'b0, 1'b1, 1'b1, 2'b10, 3);
      drive(1'b0, 1'b1, 1'b0, 2'b10, 2);
      drive(1'b0, 1'b1, 1'b1, 2'b11, 10);
      // R11: mode changes in the middle of a transfer
      drive(1'b1, 1'b1, 1'b1, 2'b00, 3);
      drive(1'b0, 1'b1, 1'b1, 2'b01, 2);
      drive(1'b0, 1'b1, 1'b1, 2'b10, 6);
      // R10: grant lost at the end with request still present
      drive(1'b1, 1'b1, 1'b1, 2'b01, 4);
      drive(1'b1, 1'b0, 1'b1, 2'b01, 5);
      drive(1'b1, 1'b1, 1'b1, 2'b01, 3);
      drive(1'b0, 1'b1, 1'b1, 2'b01, 8);
      // mixed random traffic across all requirements
      for (int k = 0; k < 4000; k++) begin
         logic [7:0] r8;
         r8 = 8'($urandom);
         drive(r8[0] | r8[1], r8[2] | r8[3] | r8[4], r8[5] | r8[6], r8[7:6], 1);
      end
      // R1: reset mid-activity
      drive(1'b1, 1'b1, 1'b1, 2'b00, 3);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      drive(1'b0, 1'b0, 1'b1, 2'b00, 4);
      finish_run();
   end

endmodule